// File: doc/BRIEF.md
# Counter Clock and Interrupt Routing Glue

This block is the bus-side glue logic of an 8-bit ISA-style I/O card that carries two parallel-port devices and one triple-counter device. It decodes a 16-byte I/O window. Six strap inputs give address bits 9 to 4 of the window. An open strap reads as 1 and a fitted strap as 0, so with all straps at their default the window sits at 0x300. Inside the window, each group of four offsets goes to one chip select, except the top four offsets, which reach two local control registers.

The first local register picks the clock of each counter. A counter can take its external input pin or the on-board oscillator. Counters 1 and 2 can also take the output of the counter below them, which cascades them into a 32- or 48-bit chain. The second local register picks a source for each of three interrupt lines and enables each line. An interrupt line is only ever driven high. When it is not active, its drive enable is off, so other cards can share the same level.

Top module: `ctr_irq_glue`

## Requirements
- R1: The window matches when `bus_aen` is 0 and `bus_addr[9:4]` equals `strap_addr`. With `bus_aen` at 1 or a different base, no select is active and `bus_doe` stays 0.
- R2: Within the window, offsets 0-3 assert `sel_pio[0]`, offsets 4-7 assert `sel_pio[1]` and offsets 8-11 assert `sel_ctr`. Offsets 12-15 assert none of them. At most one select is active at any time.
- R3: Offsets 12 and 13 both reach the clock-select register. Offsets 14 and 15 both reach the interrupt register.
- R4: `bus_doe` is 1 only while `bus_ior_n` is 0 and the window matches at offsets 12-15. The read value has unused bits at 0: bits 7:5 of the clock-select register and bits 7:6 of the interrupt register.
- R5: A write lands in the addressed local register at the first clock on which `bus_iow_n` is seen high after being low. The address and data are those held while the strobe was low. A write outside the window, or to offsets 0-11, leaves both registers unchanged.
- R6: Bit 0 of the clock-select register picks counter 0's clock: 0 gives `ctr_ext_in[0]`, 1 gives `osc_clk`.
- R7: Bits 2:1 of the clock-select register pick counter 1's clock: 00 gives `ctr_ext_in[1]`, 01 gives `osc_clk`, 1x gives `ctr_out[0]`. Bits 4:3 pick counter 2's clock in the same way, from `ctr_ext_in[2]`, `osc_clk` or `ctr_out[1]`.
- R8: In the interrupt register, bits 2:0 enable lines 2:0 and bits 5:3 pick the sources of lines 2:0. A source bit of 0 picks `pio_c0[0]` for line 0, `pio_c0[1]` for line 1 and `ext_irq` for line 2. A source bit of 1 picks `ctr_out[k]` for line k.
- R9: `irq_drive[k]` is 1, meaning the line is driven high, only while line k is enabled and its selected source is 1. Otherwise the line is left undriven (high impedance).
- R10: After reset, both local registers read 0x00. All counters then use their external inputs and all interrupt lines are undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | I/O address |
| bus_aen | input | 1 | Address enable (1 = DMA cycle, ignore) |
| bus_ior_n | input | 1 | Active-low I/O read strobe |
| bus_iow_n | input | 1 | Active-low I/O write strobe |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data |
| bus_doe | output | 1 | Read data drive enable |
| strap_addr | input | 6 | Base address bits 9:4 (open strap = 1) |
| sel_pio | output | 2 | Parallel-port device selects |
| sel_ctr | output | 1 | Counter device select |
| ctr_ext_in | input | 3 | External counter input pins |
| osc_clk | input | 1 | On-board oscillator clock |
| ctr_out | input | 3 | Counter outputs |
| ctr_clk | output | 3 | Routed counter clocks |
| pio_c0 | input | 2 | Bit C0 of each parallel port |
| ext_irq | input | 1 | External interrupt pin |
| irq_drive | output | 3 | Interrupt line drive enables (drive high when 1) |

## Verification
A corrupted control register shows at the ports on the same cycle. The counter clock routes and the interrupt drive enables are combinational from the registers, so a wrong bit misroutes a clock or drives a line the moment that register is wrong. A register that takes a write late or early shows on the first clock after the write strobe rises, through both the routing outputs and the read-back at the aliased offsets. A decode fault shows as a missing or doubled select, or as stray read drive, on the very access that hits the bad offset. That is why every strap setting is paired with every offset.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 8;
  localparam int OFF_W    = 4;
  localparam int STRAP_W  = ADDR_W - OFF_W;
  localparam int N_CTR    = 3;
  localparam int N_IRQ    = 3;
  localparam int N_PIO    = 2;
  localparam int CSEL_W   = 2 * N_CTR - 1;
  localparam int IRQR_W   = 2 * N_IRQ;

  typedef enum logic [1:0] {
    GRP_PIO0  = 2'd0,
    GRP_PIO1  = 2'd1,
    GRP_CTR   = 2'd2,
    GRP_LOCAL = 2'd3
  } grp_e;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W
) (
  input  logic [AW-1:0]    addr,
  input  logic             aen,
  input  logic [AW-OW-1:0] strap,
  output logic             hit,
  output logic [N_PIO-1:0] sel_pio,
  output logic             sel_ctr,
  output logic             sel_local,
  output logic             local_idx
);
  grp_e grp;

  always_comb begin
    hit       = !aen && (addr[AW-1:OW] == strap);
    grp       = grp_e'(addr[OW-1:OW-2]);
    sel_ctr   = hit && (grp == GRP_CTR);
    sel_local = hit && (grp == GRP_LOCAL);
    local_idx = addr[1];
  end

  for (genvar p = 0; p < N_PIO; p++) begin : g_pio
    assign sel_pio[p] = hit && (grp == grp_e'(p));
  end
endmodule

// File: rtl/glue_cfg.sv
module glue_cfg
  import glue_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CSEL_W,
  parameter int IW = IRQR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iow_n,
  input  logic          sel_local,
  input  logic          local_idx,
  input  logic [DW-1:0] din,
  output logic          wr_pulse,
  output logic [CW-1:0] csel_q,
  output logic [IW-1:0] irqr_q
);
  logic          iow_q, iow_d;
  logic          cap_hit_q, cap_hit_d;
  logic          cap_idx_q, cap_idx_d;
  logic [DW-1:0] cap_dat_q, cap_dat_d;
  logic [CW-1:0] csel_d;
  logic [IW-1:0] irqr_d;
  logic          cap_en, csel_en, irqr_en;

  always_comb begin
    iow_d     = iow_n;
    cap_en    = !iow_n;
    cap_hit_d = sel_local;
    cap_idx_d = local_idx;
    cap_dat_d = din;
    wr_pulse  = iow_n && !iow_q;
    csel_en   = wr_pulse && cap_hit_q && !cap_idx_q;
    irqr_en   = wr_pulse && cap_hit_q &&  cap_idx_q;
    csel_d    = cap_dat_q[CW-1:0];
    irqr_d    = cap_dat_q[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iow_q <= 1'b1;
    else        iow_q <= iow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_hit_q <= 1'b0;
      cap_idx_q <= 1'b0;
      cap_dat_q <= '0;
    end else if (cap_en) begin
      cap_hit_q <= cap_hit_d;
      cap_idx_q <= cap_idx_d;
      cap_dat_q <= cap_dat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csel_q <= '0;
    else if (csel_en) csel_q <= csel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irqr_q <= '0;
    else if (irqr_en) irqr_q <= irqr_d;
  end
endmodule

// File: rtl/glue_clk_route.sv
module glue_clk_route
  import glue_pkg::*;
#(
  parameter int NC = N_CTR,
  parameter int CW = 2 * NC - 1
) (
  input  logic [CW-1:0] csel,
  input  logic [NC-1:0] ext_in,
  input  logic          osc,
  input  logic [NC-1:0] cout,
  output logic [NC-1:0] cclk
);
  for (genvar k = 0; k < NC; k++) begin : g_mux
    if (k == 0) begin : g_first
      assign cclk[0] = csel[0] ? osc : ext_in[0];
    end else begin : g_chain
      logic [1:0] s;
      assign s = csel[2*k:2*k-1];
      always_comb begin
        if (s[1])      cclk[k] = cout[k-1];
        else if (s[0]) cclk[k] = osc;
        else           cclk[k] = ext_in[k];
      end
    end
  end
endmodule

// File: rtl/glue_irq_route.sv
module glue_irq_route
  import glue_pkg::*;
#(
  parameter int NI = N_IRQ
) (
  input  logic [2*NI-1:0] irqr,
  input  logic [NI-1:0]   alt_src,
  input  logic [NI-1:0]   cout,
  output logic [NI-1:0]   drive
);
  for (genvar k = 0; k < NI; k++) begin : g_line
    logic src;
    assign src      = irqr[NI+k] ? cout[k] : alt_src[k];
    assign drive[k] = irqr[k] && src;
  end
endmodule

// File: rtl/ctr_irq_glue.sv
module ctr_irq_glue
  import glue_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_aen,
  input  logic               bus_ior_n,
  input  logic               bus_iow_n,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic [N_PIO-1:0]   sel_pio,
  output logic               sel_ctr,
  input  logic [N_CTR-1:0]   ctr_ext_in,
  input  logic               osc_clk,
  input  logic [N_CTR-1:0]   ctr_out,
  output logic [N_CTR-1:0]   ctr_clk,
  input  logic [N_PIO-1:0]   pio_c0,
  input  logic               ext_irq,
  output logic [N_IRQ-1:0]   irq_drive
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              hit, sel_local, local_idx, wr_pulse;
  logic [CSEL_W-1:0] csel_q;
  logic [IRQR_W-1:0] irqr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  glue_decode u_dec (
    .addr      (bus_addr),
    .aen       (bus_aen),
    .strap     (strap_addr),
    .hit       (hit),
    .sel_pio   (sel_pio),
    .sel_ctr   (sel_ctr),
    .sel_local (sel_local),
    .local_idx (local_idx)
  );

  glue_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .iow_n     (bus_iow_n),
    .sel_local (sel_local),
    .local_idx (local_idx),
    .din       (bus_din),
    .wr_pulse  (wr_pulse),
    .csel_q    (csel_q),
    .irqr_q    (irqr_q)
  );

  always_comb begin
    bus_doe  = sel_local && !bus_ior_n;
    bus_dout = '0;
    if (local_idx) bus_dout[IRQR_W-1:0] = irqr_q;
    else           bus_dout[CSEL_W-1:0] = csel_q;
  end

  glue_clk_route u_clk (
    .csel   (csel_q),
    .ext_in (ctr_ext_in),
    .osc    (osc_clk),
    .cout   (ctr_out),
    .cclk   (ctr_clk)
  );

  glue_irq_route u_irq (
    .irqr    (irqr_q),
    .alt_src ({ext_irq, pio_c0}),
    .cout    (ctr_out),
    .drive   (irq_drive)
  );
endmodule

// File: rtl/ctr_irq_glue_chk.sv
module ctr_irq_glue_chk
  import glue_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_aen,
  input logic              bus_ior_n,
  input logic              bus_doe,
  input logic [N_PIO-1:0]  sel_pio,
  input logic              sel_ctr,
  input logic              sel_local,
  input logic              wr_pulse,
  input logic [CSEL_W-1:0] csel_q,
  input logic [IRQR_W-1:0] irqr_q,
  input logic [N_IRQ-1:0]  irq_drive
);
  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sel_pio, sel_ctr, sel_local}));

  assert_aen_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_aen |-> (sel_pio == '0 && !sel_ctr && !sel_local && !bus_doe));

  assert_read_window_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_doe |-> (!bus_ior_n && sel_local));

  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_pulse |=> $stable({csel_q, irqr_q}));

  assert_drive_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_drive & ~irqr_q[N_IRQ-1:0]) == '0);
endmodule

bind ctr_irq_glue ctr_irq_glue_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_aen    (bus_aen),
  .bus_ior_n  (bus_ior_n),
  .bus_doe    (bus_doe),
  .sel_pio    (sel_pio),
  .sel_ctr    (sel_ctr),
  .sel_local  (sel_local),
  .wr_pulse   (wr_pulse),
  .csel_q     (csel_q),
  .irqr_q     (irqr_q),
  .irq_drive  (irq_drive)
);

// File: tb/tb_ctr_irq_glue.sv
module tb_ctr_irq_glue;
  logic       clk = 0;
  logic       rst_n;
  logic [9:0] bus_addr;
  logic       bus_aen, bus_ior_n, bus_iow_n;
  logic [7:0] bus_din, bus_dout;
  logic       bus_doe;
  logic [5:0] strap_addr;
  logic [1:0] sel_pio;
  logic       sel_ctr;
  logic [2:0] ctr_ext_in, ctr_out, ctr_clk;
  logic       osc_clk;
  logic [1:0] pio_c0;
  logic       ext_irq;
  logic [2:0] irq_drive;

  int total = 0, bad = 0;
  int m_csel = 0, m_irq = 0;
  bit cap_ok = 0, prev_iow = 1, live = 0;
  int cap_off = 0, cap_dat = 0;

  always #5 clk = ~clk;

  ctr_irq_glue dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: local registers follow completed bus writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_csel = 0; m_irq = 0; prev_iow = 1; cap_ok = 0;
    end else begin
      if (bus_iow_n && !prev_iow && cap_ok && cap_off >= 12) begin
        if (cap_off >= 14) m_irq = cap_dat & 8'h3F;
        else               m_csel = cap_dat & 8'h1F;
      end
      if (!bus_iow_n) begin
        cap_ok  = !bus_aen && (bus_addr[9:4] == strap_addr);
        cap_off = int'(bus_addr[3:0]);
        cap_dat = int'(bus_din);
      end
      prev_iow = bus_iow_n;
    end
  end

  function automatic bit exp_clk(input int k);
    int s;
    if (k == 0) return (m_csel & 1) ? osc_clk : ctr_ext_in[0];
    s = (m_csel >> (2*k - 1)) & 3;
    if (s >= 2) return ctr_out[k-1];
    if (s == 1) return osc_clk;
    return ctr_ext_in[k];
  endfunction

  function automatic bit exp_irq(input int k);
    bit src, en;
    bit [2:0] alt;
    alt = {ext_irq, pio_c0};
    en  = (m_irq >> k) & 1;
    src = ((m_irq >> (3 + k)) & 1) ? ctr_out[k] : alt[k];
    return en && src;
  endfunction

  always @(negedge clk) if (live) begin
    bit match;
    int off, es;
    bit [2:0] ec, ei;
    match = !bus_aen && (bus_addr[9:4] == strap_addr);
    off   = int'(bus_addr[3:0]);
    es = 0;
    if (match && off < 4)                es = 1;
    else if (match && off >= 4 && off < 8)  es = 2;
    else if (match && off >= 8 && off < 12) es = 4;
    chk({sel_ctr, sel_pio} == 3'(es), "R1 R2 select", int'({sel_ctr, sel_pio}), es);
    chk(bus_doe == (match && off >= 12 && !bus_ior_n), "R4 doe", int'(bus_doe),
        int'(match && off >= 12 && !bus_ior_n));
    for (int k = 0; k < 3; k++) begin
      ec[k] = exp_clk(k);
      ei[k] = exp_irq(k);
    end
    chk(ctr_clk == ec, "R6 R7 clk route", int'(ctr_clk), int'(ec));
    chk(irq_drive == ei, "R8 R9 irq drive", int'(irq_drive), int'(ei));
  end

  task automatic bus_wr(input logic [9:0] a, input logic [7:0] d, input bit aen = 0);
    @(posedge clk); #2;
    bus_addr = a; bus_din = d; bus_aen = aen; bus_iow_n = 0;
    repeat (2) @(posedge clk);
    #2 bus_iow_n = 1;
    @(posedge clk); #2 bus_aen = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, input int exp, input string tag);
    @(posedge clk); #2;
    bus_addr = a; bus_ior_n = 0;
    @(negedge clk);
    chk(bus_doe && bus_dout == 8'(exp), tag, int'(bus_dout), exp);
    @(posedge clk); #2 bus_ior_n = 1;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] base;
    rst_n = 0; bus_addr = 0; bus_aen = 0; bus_ior_n = 1; bus_iow_n = 1; bus_din = 0;
    strap_addr = 6'h30; ctr_ext_in = 0; osc_clk = 0; ctr_out = 0; pio_c0 = 0; ext_irq = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    live = 1;
    base = 10'h300;
    // R10: reset values
    bus_rd(base + 12, 0, "R10 clock-select reset");
    bus_rd(base + 14, 0, "R10 irq reg reset");
    // R10: reset routing with inputs high
    #2 ctr_ext_in = 3'b101; ctr_out = 3'b111; pio_c0 = 2'b11; ext_irq = 1;
    @(negedge clk);
    chk(ctr_clk == 3'b101, "R10 clocks external", int'(ctr_clk), 5);
    chk(irq_drive == 0, "R10 irq undriven", int'(irq_drive), 0);

    // R1 R2: all straps x all offsets, plus near-miss and aen
    for (int s = 0; s < 64; s++) begin
      @(posedge clk); #2 strap_addr = 6'(s);
      for (int o = 0; o < 16; o++) begin
        @(posedge clk); #2 bus_addr = {6'(s), 4'(o)}; bus_ior_n = o[0];
      end
      @(posedge clk); #2 bus_addr = {6'(s) ^ 6'h01, 4'd12}; bus_ior_n = 0;
      @(posedge clk); #2 bus_addr = {6'(s), 4'd13}; bus_aen = 1;
      @(posedge clk); #2 bus_aen = 0; bus_ior_n = 1;
    end
    @(posedge clk); #2 strap_addr = 6'h30;

    // R3 R4 R5: aliases and unused bits
    bus_wr(base + 13, 8'hFF);
    bus_rd(base + 12, 8'h1F, "R3 R4 alias 13->12, upper bits 0");
    bus_wr(base + 15, 8'hFF);
    bus_rd(base + 14, 8'h3F, "R3 R4 alias 15->14, upper bits 0");
    bus_wr(base + 12, 8'h0A);
    bus_rd(base + 13, 8'h0A, "R3 read alias 13");
    bus_wr(base + 14, 8'h15);
    bus_rd(base + 15, 8'h15, "R3 read alias 15");
    // R5: ignored writes
    bus_wr(10'h310 + 12, 8'h00);
    bus_wr(base + 14, 8'h00, 1);
    bus_wr(base + 8, 8'h00);
    bus_rd(base + 12, 8'h0A, "R5 ignored writes csel");
    bus_rd(base + 14, 8'h15, "R5 ignored writes irq");

    // R6 R7: every select code against varied inputs
    for (int c = 0; c < 32; c++) begin
      bus_wr(base + 12, 8'(c));
      for (int p = 0; p < 16; p++) begin
        @(posedge clk); #2 {ctr_out, ctr_ext_in, osc_clk} = 7'(p * 37 + c);
      end
    end
    // R8 R9: every irq setting against all source patterns
    for (int r = 0; r < 64; r++) begin
      bus_wr(base + 14, 8'(r));
      for (int p = 0; p < 64; p++) begin
        @(posedge clk); #2 {ctr_out, ext_irq, pio_c0} = 6'(p);
      end
    end

    live = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule